// File: doc/BRIEF.md
# Radio Task Termination Controller

This block decides when and how a running radio task ends. A task is opened by a start pulse carrying the start kind and three parameter fields. The block checks those fields before the task runs, and while the task runs it watches host commands and a timer stop event. It then ends the task in one of three ways: at once (kill), after the packet in flight finishes (graceful), or with an error when the parameters are rejected. It also keeps the programmed channel word and leaves it untouched for the reserved channel code.

The states are IDLE, RUN, DRAIN and ENDING. An accepted start takes IDLE to RUN. A rejected start takes IDLE to ENDING with the error reason. In RUN, a kill condition moves to ENDING with the kill reason. A stop condition moves to DRAIN when a packet is in flight, and to ENDING with the graceful reason when none is. In DRAIN, a kill condition moves to ENDING with the kill reason, and the packet-done strobe moves to ENDING with the graceful reason. ENDING always returns to IDLE on the next clock. Packet transmission and reception are not part of the block. They appear only as status inputs.

Top module: `rtt_term_ctrl`

## Requirements
- R1: In RUN or DRAIN, `cmd_shutdown`, `cmd_undef` or `cmd_newtask` sampled at a clock edge gives `end_now` high for the one cycle after that edge.
- R2: `abort_irq` is high together with `end_now` exactly when `pkt_active` was high at the edge that took the kill. Otherwise it stays low.
- R3: A stop (`cmd_stop` in RUN) with `pkt_active` low gives `end_graceful` in the next cycle. With `pkt_active` high and no `pkt_done`, it raises `stop_pending` until a `pkt_done` edge, and `end_graceful` follows in the next cycle.
- R4: A kill condition that arrives while `stop_pending` is high wins: `end_now` is raised and `end_graceful` is not.
- R5: For `stop_cfg` 2'b00, `tmr_stop_evt` has no effect. For 2'b01 it acts as `cmd_stop`. For 2'b10 it acts as `cmd_shutdown`.
- R6: For `stop_cfg` 2'b11, `tmr_stop_evt` acts as `cmd_shutdown` only while `in_search` is high, no packet has been active or done since the start, and `start_kind` is 2'b00 (receive), 2'b01 (transmit on clear channel) or 2'b10 (timer start). For 2'b11 (plain transmit) it is ignored.
- R7: A start with `chan` above 80 and not 127, with `txaddr_cfg` equal to 2'b11, or with `crc_len` above 4 does not run. Instead `end_error` is high in the next cycle.
- R8: An accepted start with `chan` other than 127 loads `freq_word` with `chan` and pulses `freq_load` in the next cycle. With `chan` equal to 127, `freq_word` keeps its value and `freq_load` stays low.
- R9: After reset all outputs are 0. Any end output lasts one cycle and then the block is IDLE. Commands and timer events in IDLE, and `task_start` during RUN or DRAIN, have no effect. At most one of `end_now`, `end_graceful` and `end_error` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| task_start | input | 1 | Start pulse for a new task |
| start_kind | input | 2 | 00 receive, 01 transmit on clear channel, 10 timer start, 11 plain transmit |
| chan | input | 7 | Channel field to check and program |
| txaddr_cfg | input | 2 | Transmit address configuration field |
| crc_len | input | 3 | CRC length field |
| cmd_shutdown | input | 1 | Shutdown command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_undef | input | 1 | Undefined command pulse |
| cmd_newtask | input | 1 | Command that starts another task |
| tmr_stop_evt | input | 1 | Timer stop event pulse |
| stop_cfg | input | 2 | Timer stop event handling mode |
| pkt_active | input | 1 | A packet is being sent or received |
| pkt_done | input | 1 | Packet completion strobe |
| in_search | input | 1 | Task is in sync search or listen |
| end_now | output | 1 | Immediate end strobe |
| end_graceful | output | 1 | End after a stop strobe |
| stop_pending | output | 1 | Stop waiting for the current packet |
| abort_irq | output | 1 | Abort interrupt pulse to the host |
| end_error | output | 1 | Parameter error end strobe |
| freq_load | output | 1 | Channel word was programmed |
| freq_word | output | 7 | Last programmed channel word |

## Verification
Every registered result appears in the cycle after the edge that samples its cause. `end_now`, `abort_irq`, `end_graceful`, `end_error`, `freq_load` and `freq_word` all follow this rule. `stop_pending` rises in the cycle after the stop edge and falls in the cycle after the resolving edge. The bench changes inputs only at falling edges and compares every output at the next falling edge with a cycle model built from the requirements, so each comparison sees exactly one edge's effect. Directed sequences add tagged checks at those same falling edges for the corner cases.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_ENDING = 2'd3
    } rtt_state_e;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'd0,
        RSN_KILL  = 2'd1,
        RSN_GRACE = 2'd2,
        RSN_ERR   = 2'd3
    } rtt_reason_e;

    typedef enum logic [1:0] {
        SK_RX    = 2'd0,
        SK_TXCC  = 2'd1,
        SK_TIMER = 2'd2,
        SK_TX    = 2'd3
    } rtt_kind_e;

    typedef enum logic [1:0] {
        SC_OFF      = 2'd0,
        SC_AS_STOP  = 2'd1,
        SC_AS_KILL  = 2'd2,
        SC_PHASED   = 2'd3
    } rtt_stopcfg_e;

endpackage

// File: rtl/rtt_param_check.sv
module rtt_param_check #(
    parameter int CHAN_W    = 7,
    parameter int CHAN_MAX  = 80,
    parameter int CHAN_KEEP = 127,
    parameter int ADDR_W    = 2,
    parameter int ADDR_BAD  = 3,
    parameter int CRC_W     = 3,
    parameter int CRC_MAX   = 4
) (
    input  logic [CHAN_W-1:0] chan,
    input  logic [ADDR_W-1:0] txaddr_cfg,
    input  logic [CRC_W-1:0]  crc_len,
    output logic              params_ok
);
    localparam logic [CHAN_W-1:0] CHAN_LIM  = CHAN_W'(CHAN_MAX);
    localparam logic [CHAN_W-1:0] CHAN_SKIP = CHAN_W'(CHAN_KEEP);
    localparam logic [ADDR_W-1:0] ADDR_REJ  = ADDR_W'(ADDR_BAD);
    localparam logic [CRC_W-1:0]  CRC_LIM   = CRC_W'(CRC_MAX);

    logic chan_ok;
    logic addr_ok;
    logic crc_ok;

    always_comb begin
        chan_ok   = (chan <= CHAN_LIM) || (chan == CHAN_SKIP);
        addr_ok   = (txaddr_cfg != ADDR_REJ);
        crc_ok    = (crc_len <= CRC_LIM);
        params_ok = chan_ok && addr_ok && crc_ok;
    end
endmodule

// File: rtl/rtt_event_gate.sv
module rtt_event_gate
    import rtt_pkg::*;
(
    input  logic       tmr_evt,
    input  logic [1:0] stop_cfg,
    input  logic       in_search,
    input  logic       first_phase,
    input  rtt_kind_e  kind,
    output logic       evt_stop,
    output logic       evt_kill
);
    logic phase_ok;

    always_comb begin
        phase_ok = in_search && first_phase && (kind != SK_TX);
        evt_stop = 1'b0;
        evt_kill = 1'b0;
        unique case (rtt_stopcfg_e'(stop_cfg))
            SC_OFF:     ;
            SC_AS_STOP: evt_stop = tmr_evt;
            SC_AS_KILL: evt_kill = tmr_evt;
            SC_PHASED:  evt_kill = tmr_evt && phase_ok;
            default:    ;
        endcase
    end
endmodule

// File: rtl/rtt_freq_hold.sv
module rtt_freq_hold #(
    parameter int CHAN_W    = 7,
    parameter int CHAN_KEEP = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [CHAN_W-1:0] chan,
    output logic [CHAN_W-1:0] freq_word,
    output logic              freq_load
);
    localparam logic [CHAN_W-1:0] CHAN_SKIP = CHAN_W'(CHAN_KEEP);

    logic do_load;

    always_comb do_load = load_req && (chan != CHAN_SKIP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_word <= '0;
            freq_load <= 1'b0;
        end else begin
            freq_load <= do_load;
            if (do_load) begin
                freq_word <= chan;
            end
        end
    end

    // R8: the reserved channel code leaves the word alone
    p_keep_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && chan == CHAN_SKIP) |=> (freq_word == $past(freq_word)) && !freq_load);
endmodule

// File: rtl/rtt_term_ctrl.sv
module rtt_term_ctrl
    import rtt_pkg::*;
#(
    parameter int CHAN_W    = 7,
    parameter int CHAN_MAX  = 80,
    parameter int CHAN_KEEP = 127,
    parameter int ADDR_W    = 2,
    parameter int ADDR_BAD  = 3,
    parameter int CRC_W     = 3,
    parameter int CRC_MAX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic [1:0]        start_kind,
    input  logic [CHAN_W-1:0] chan,
    input  logic [ADDR_W-1:0] txaddr_cfg,
    input  logic [CRC_W-1:0]  crc_len,
    input  logic              cmd_shutdown,
    input  logic              cmd_stop,
    input  logic              cmd_undef,
    input  logic              cmd_newtask,
    input  logic              tmr_stop_evt,
    input  logic [1:0]        stop_cfg,
    input  logic              pkt_active,
    input  logic              pkt_done,
    input  logic              in_search,
    output logic              end_now,
    output logic              end_graceful,
    output logic              stop_pending,
    output logic              abort_irq,
    output logic              end_error,
    output logic              freq_load,
    output logic [CHAN_W-1:0] freq_word
);
    rtt_state_e  state_q, state_d;
    rtt_reason_e reason_q, reason_d;
    rtt_kind_e   kind_q, kind_d;
    logic        abort_q, abort_d;
    logic        first_q, first_d;

    logic params_ok;
    logic evt_stop;
    logic evt_kill;
    logic kill_req;
    logic stop_req;
    logic accept;

    rtt_param_check #(
        .CHAN_W   (CHAN_W),
        .CHAN_MAX (CHAN_MAX),
        .CHAN_KEEP(CHAN_KEEP),
        .ADDR_W   (ADDR_W),
        .ADDR_BAD (ADDR_BAD),
        .CRC_W    (CRC_W),
        .CRC_MAX  (CRC_MAX)
    ) u_check (
        .chan      (chan),
        .txaddr_cfg(txaddr_cfg),
        .crc_len   (crc_len),
        .params_ok (params_ok)
    );

    rtt_event_gate u_gate (
        .tmr_evt    (tmr_stop_evt),
        .stop_cfg   (stop_cfg),
        .in_search  (in_search),
        .first_phase(first_q),
        .kind       (kind_q),
        .evt_stop   (evt_stop),
        .evt_kill   (evt_kill)
    );

    always_comb begin
        kill_req = cmd_shutdown || cmd_undef || cmd_newtask || evt_kill;
        stop_req = cmd_stop || evt_stop;
        accept   = (state_q == ST_IDLE) && task_start && params_ok;
    end

    rtt_freq_hold #(
        .CHAN_W   (CHAN_W),
        .CHAN_KEEP(CHAN_KEEP)
    ) u_freq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (accept),
        .chan     (chan),
        .freq_word(freq_word),
        .freq_load(freq_load)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            reason_q <= RSN_NONE;
            kind_q   <= SK_RX;
            abort_q  <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            reason_q <= reason_d;
            kind_q   <= kind_d;
            abort_q  <= abort_d;
            first_q  <= first_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        reason_d = reason_q;
        kind_d   = kind_q;
        abort_d  = abort_q;
        first_d  = first_q && !(pkt_active || pkt_done);
        unique case (state_q)
            ST_IDLE: begin
                reason_d = RSN_NONE;
                abort_d  = 1'b0;
                first_d  = 1'b0;
                if (task_start) begin
                    if (params_ok) begin
                        state_d = ST_RUN;
                        kind_d  = rtt_kind_e'(start_kind);
                        first_d = 1'b1;
                    end else begin
                        state_d  = ST_ENDING;
                        reason_d = RSN_ERR;
                    end
                end
            end
            ST_RUN: begin
                if (kill_req) begin
                    state_d  = ST_ENDING;
                    reason_d = RSN_KILL;
                    abort_d  = pkt_active;
                end else if (stop_req) begin
                    if (pkt_active && !pkt_done) begin
                        state_d = ST_DRAIN;
                    end else begin
                        state_d  = ST_ENDING;
                        reason_d = RSN_GRACE;
                    end
                end
            end
            ST_DRAIN: begin
                if (kill_req) begin
                    state_d  = ST_ENDING;
                    reason_d = RSN_KILL;
                    abort_d  = pkt_active;
                end else if (pkt_done) begin
                    state_d  = ST_ENDING;
                    reason_d = RSN_GRACE;
                end
            end
            ST_ENDING: begin
                state_d  = ST_IDLE;
                reason_d = RSN_NONE;
                abort_d  = 1'b0;
                first_d  = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        end_now      = 1'b0;
        end_graceful = 1'b0;
        end_error    = 1'b0;
        abort_irq    = 1'b0;
        stop_pending = (state_q == ST_DRAIN);
        if (state_q == ST_ENDING) begin
            unique case (reason_q)
                RSN_KILL:  begin
                    end_now   = 1'b1;
                    abort_irq = abort_q;
                end
                RSN_GRACE: end_graceful = 1'b1;
                RSN_ERR:   end_error    = 1'b1;
                default:   ;
            endcase
        end
    end

    // R1: a shutdown command during a task ends it next cycle
    p_shutdown_kills_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_DRAIN) && cmd_shutdown) |=> end_now);

    // R2: the abort interrupt only comes with an immediate end
    p_abort_with_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |-> end_now);

    // R3: a pending stop resolves on packet done
    p_pending_resolves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pending && pkt_done && !kill_req) |=> end_graceful);

    // R5: mode 00 leaves a running task untouched by the timer event
    p_cfg_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_cfg == 2'b00 && tmr_stop_evt && !cmd_shutdown &&
         !cmd_stop && !cmd_undef && !cmd_newtask) |=> (state_q == ST_RUN));

    // R7: rejected parameters end with an error
    p_bad_params_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && task_start && !params_ok) |=> end_error);

    // R9: end indications are exclusive and one cycle long
    p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({end_now, end_graceful, end_error}));

    p_idle_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_now || end_graceful || end_error) |=> (state_q == ST_IDLE));
endmodule

// File: tb/rtt_term_ctrl_test.sv
module rtt_term_ctrl_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic       task_start;
    logic [1:0] start_kind;
    logic [6:0] chan;
    logic [1:0] txaddr_cfg;
    logic [2:0] crc_len;
    logic       cmd_shutdown, cmd_stop, cmd_undef, cmd_newtask;
    logic       tmr_stop_evt;
    logic [1:0] stop_cfg;
    logic       pkt_active, pkt_done, in_search;
    logic       end_now, end_graceful, stop_pending, abort_irq, end_error, freq_load;
    logic [6:0] freq_word;

    rtt_term_ctrl uut (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .start_kind(start_kind),
        .chan(chan), .txaddr_cfg(txaddr_cfg), .crc_len(crc_len),
        .cmd_shutdown(cmd_shutdown), .cmd_stop(cmd_stop), .cmd_undef(cmd_undef),
        .cmd_newtask(cmd_newtask), .tmr_stop_evt(tmr_stop_evt), .stop_cfg(stop_cfg),
        .pkt_active(pkt_active), .pkt_done(pkt_done), .in_search(in_search),
        .end_now(end_now), .end_graceful(end_graceful), .stop_pending(stop_pending),
        .abort_irq(abort_irq), .end_error(end_error), .freq_load(freq_load),
        .freq_word(freq_word)
    );

    int checks = 0;
    int errors = 0;

    // cycle model: 0 idle, 1 run, 2 drain, 3 ending; reason 1 kill, 2 graceful, 3 error
    int         m_st = 0, m_rsn = 0, m_kind = 0;
    bit         m_abort = 0, m_first = 0, m_fload = 0;
    logic [6:0] m_freq = '0;

    function automatic bit f_valid(logic [6:0] c, logic [1:0] a, logic [2:0] l);
        return ((c <= 7'd80) || (c == 7'd127)) && (a != 2'b11) && (l <= 3'd4);
    endfunction

    function automatic bit f_kill(bit sd, bit ud, bit nt, bit te, logic [1:0] cfg,
                                  bit srch, bit first, int kind);
        bit phased = (cfg == 2'b11) && te && srch && first && (kind != 3);
        return sd || ud || nt || ((cfg == 2'b10) && te) || phased;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rsn = 0; m_kind = 0; m_abort = 0; m_first = 0; m_fload = 0; m_freq = '0;
        end else begin
            bit kill, stp, nfirst;
            kill = f_kill(cmd_shutdown, cmd_undef, cmd_newtask, tmr_stop_evt, stop_cfg,
                          in_search, m_first, m_kind);
            stp  = cmd_stop || ((stop_cfg == 2'b01) && tmr_stop_evt);
            nfirst = m_first && !(pkt_active || pkt_done);
            m_fload = 0;
            case (m_st)
                0: begin
                    nfirst = 0;
                    if (task_start) begin
                        if (f_valid(chan, txaddr_cfg, crc_len)) begin
                            m_st = 1; m_kind = int'(start_kind); nfirst = 1;
                            if (chan != 7'd127) begin m_freq = chan; m_fload = 1; end
                        end else begin
                            m_st = 3; m_rsn = 3; m_abort = 0;
                        end
                    end
                end
                1: begin
                    if (kill) begin m_st = 3; m_rsn = 1; m_abort = pkt_active; end
                    else if (stp) begin
                        if (pkt_active && !pkt_done) m_st = 2;
                        else begin m_st = 3; m_rsn = 2; m_abort = 0; end
                    end
                end
                2: begin
                    if (kill) begin m_st = 3; m_rsn = 1; m_abort = pkt_active; end
                    else if (pkt_done) begin m_st = 3; m_rsn = 2; m_abort = 0; end
                end
                default: begin m_st = 0; m_rsn = 0; m_abort = 0; nfirst = 0; end
            endcase
            m_first = nfirst;
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        check_bit("R1 end_now", end_now, m_st == 3 && m_rsn == 1);
        check_bit("R2 abort_irq", abort_irq, m_st == 3 && m_rsn == 1 && m_abort);
        check_bit("R3 end_graceful", end_graceful, m_st == 3 && m_rsn == 2);
        check_bit("R3 stop_pending", stop_pending, m_st == 2);
        check_bit("R7 end_error", end_error, m_st == 3 && m_rsn == 3);
        check_bit("R8 freq_load", freq_load, m_fload);
        checks++;
        if (freq_word !== m_freq) begin
            errors++;
            $display("FAIL R8 freq_word actual=%0d expected=%0d", freq_word, m_freq);
        end
    endtask

    task automatic clear_pulses();
        task_start = 0; cmd_shutdown = 0; cmd_stop = 0; cmd_undef = 0; cmd_newtask = 0;
        tmr_stop_evt = 0; pkt_done = 0;
    endtask

    // one clock: inputs already driven; compare at next falling edge, then clear pulses
    task automatic tick();
        @(negedge clk);
        cmp_all();
        clear_pulses();
    endtask

    task automatic start_task(logic [1:0] kind, logic [6:0] ch);
        task_start = 1; start_kind = kind; chan = ch; txaddr_cfg = 2'b00; crc_len = 3'd2;
        tick();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; clear_pulses();
        start_kind = 0; chan = 0; txaddr_cfg = 0; crc_len = 0; stop_cfg = 0;
        pkt_active = 0; in_search = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check_bit("R9 reset end_now", end_now, 0);
        check_bit("R9 reset stop_pending", stop_pending, 0);
        check_bit("R9 reset freq_load", freq_load, 0);
        check_bit("R9 reset freq_word0", freq_word[0], 0);

        // R9 commands in idle do nothing
        cmd_shutdown = 1; cmd_stop = 1; tmr_stop_evt = 1; stop_cfg = 2'b10; tick();
        check_bit("R9 idle command ignored", end_now | end_graceful, 0);

        // R7 bad channel, bad address config, bad crc length
        task_start = 1; chan = 7'd81; txaddr_cfg = 0; crc_len = 0; tick();
        check_bit("R7 chan 81 error", end_error, 1);
        tick();
        check_bit("R9 back to idle", end_error, 0);
        task_start = 1; chan = 7'd5; txaddr_cfg = 2'b11; tick();
        check_bit("R7 addr cfg 3 error", end_error, 1);
        tick();
        task_start = 1; txaddr_cfg = 2'b01; crc_len = 3'd5; tick();
        check_bit("R7 crc len 5 error", end_error, 1);
        check_bit("R7 no load on error", freq_load, 0);
        tick();

        // R8 load and keep
        stop_cfg = 2'b00;
        start_task(2'b00, 7'd10);
        check_bit("R8 load pulse", freq_load, 1);
        check_bit("R8 word bit1", freq_word[1], 1);
        // R9 start ignored while running
        task_start = 1; chan = 7'd200 >> 1; tick();
        check_bit("R9 start in run ignored", freq_load | end_error, 0);
        // R1 shutdown without packet, R2 no abort
        cmd_shutdown = 1; tick();
        check_bit("R1 shutdown end", end_now, 1);
        check_bit("R2 no abort idle packet", abort_irq, 0);
        tick();
        start_task(2'b01, 7'd127);
        check_bit("R8 keep no pulse", freq_load, 0);
        check_bit("R8 keep word", freq_word == 7'd10, 1);

        // R2 abort with packet in flight (undefined command)
        pkt_active = 1; cmd_undef = 1; tick();
        check_bit("R2 abort with packet", abort_irq, 1);
        tick();

        // R3 deferred stop
        start_task(2'b11, 7'd3);
        cmd_stop = 1; tick();
        check_bit("R3 pending", stop_pending, 1);
        check_bit("R3 not yet ended", end_graceful, 0);
        tick(); tick();
        check_bit("R3 still pending", stop_pending, 1);
        pkt_done = 1; pkt_active = 0; tick();
        check_bit("R3 graceful after done", end_graceful, 1);
        tick();

        // R4 kill overrides pending stop
        start_task(2'b00, 7'd4);
        pkt_active = 1; cmd_stop = 1; tick();
        cmd_newtask = 1; tick();
        check_bit("R4 kill wins", end_now, 1);
        check_bit("R4 no graceful", end_graceful, 0);
        tick();

        // R5 timer modes
        start_task(2'b00, 7'd6);
        stop_cfg = 2'b00; tmr_stop_evt = 1; tick();
        check_bit("R5 cfg00 ignored", end_now | end_graceful | stop_pending, 0);
        stop_cfg = 2'b01; tmr_stop_evt = 1; tick();
        check_bit("R5 cfg01 acts as stop", stop_pending, 1);
        stop_cfg = 2'b10; tmr_stop_evt = 1; tick();
        check_bit("R5 cfg10 acts as shutdown", end_now, 1);
        tick();

        // R6 phase-restricted mode
        pkt_active = 0; stop_cfg = 2'b11; in_search = 1;
        start_task(2'b11, 7'd7);
        tmr_stop_evt = 1; tick();
        check_bit("R6 plain tx ignored", end_now, 0);
        cmd_shutdown = 1; tick(); tick();
        start_task(2'b10, 7'd8);
        pkt_active = 1; tick();
        pkt_active = 0; tmr_stop_evt = 1; tick();
        check_bit("R6 after packet ignored", end_now, 0);
        cmd_shutdown = 1; tick(); tick();
        start_task(2'b00, 7'd9);
        tmr_stop_evt = 1; tick();
        check_bit("R6 first search honoured", end_now, 1);
        tick();

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            task_start   = ($urandom_range(0, 3) == 0);
            start_kind   = 2'($urandom_range(0, 3));
            chan         = ($urandom_range(0, 7) == 0) ? 7'd127 : 7'($urandom_range(0, 90));
            txaddr_cfg   = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            crc_len      = 3'($urandom_range(0, 5));
            cmd_shutdown = ($urandom_range(0, 40) == 0);
            cmd_stop     = ($urandom_range(0, 15) == 0);
            cmd_undef    = ($urandom_range(0, 60) == 0);
            cmd_newtask  = ($urandom_range(0, 60) == 0);
            tmr_stop_evt = ($urandom_range(0, 10) == 0);
            stop_cfg     = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) pkt_active = ~pkt_active;
            pkt_done     = ($urandom_range(0, 8) == 0);
            if ($urandom_range(0, 3) == 0) in_search = ~in_search;
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule